// File: doc/BRIEF.md
# Register-Programmed Panel Command SPI Master

This block lets a display controller send short configuration commands to a panel over a serial link. Software uses a small memory-mapped register window. It writes a transmit word and a control word that holds the divider, the frame lengths, the clock polarity, the port and the wire mode. It then raises a start bit, polls a sticky completion flag, and lowers start again. One start produces one frame of 2 to 32 transmit bits, sent MSB first from a right-aligned data word.

In 4-wire mode the block samples the input line on every transmit bit. In 3-wire mode the data line is shared. After the transmit bits, the block releases the line and clocks in a separately programmed number of receive bits. Either way, the received bits can be read back right-aligned. Two identical pin groups are provided, and only the selected group is driven. The chip select can be held asserted across frames.

Top module: `panel_spi_master`

## Requirements
- R1: Register window: control at 0x180, transmit data at 0x184, receive data at 0x188 (read only), status at 0x18C (bit 0 = done). All registers reset to zero. Control bits 5 and 4 always read back as zero, and the other control bits read back as written.
- R2: A frame starts only on a 0-to-1 change of control bit 0 (start) while control bit 3 (enable) is 1 and no frame is running. Setting start while enable is 0 starts nothing. Keeping start at 1 after a frame never starts a second frame.
- R3: The transmit length is control[15:8] plus one bits. A field value of 0 counts as 2 bits, and values above 31 count as 32 bits. The low bits of the transmit word are sent MSB first, and bits above the length are never sent.
- R4: Each serial clock half-period lasts control[31:24] system clock cycles. Divider values below 2 count as 2.
- R5: Control bit 7 sets the idle level of the serial clock. The output data is stable when the clock first leaves its idle level within a bit, and the input is sampled at that edge.
- R6: Control bit 2 picks port 1 (1) or port 0 (0). The other port keeps its clock at the idle level, its chip select high and its output enable low.
- R7: In 4-wire mode (control bit 1 = 0), the block samples the port input once per transmit bit. At the end of the frame, the receive register holds those bits right-aligned, with the first-sampled bit highest.
- R8: In 3-wire mode (control bit 1 = 1), the transmit bits are followed by control[23:16] plus one receive clocks, using the same clamping as R3. During these clocks the output enable is low, and the sampled bits go to the receive register right-aligned.
- R9: The done flag (status bit 0, also the xfer_done pin) is set at the end of each frame. It stays set until a status write with bit 0 at zero, and a write with bit 0 at one leaves it set.
- R10: With control bit 6 (keep) set and enable set, the chip select stays asserted after the frame. It is released when keep or enable is cleared. Without keep, it is released at the end of the frame.
- R11: After reset, both chip selects are high, both clocks are low, both output enables are low and done is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| xfer_done | output | 1 | Sticky frame-complete flag |
| spi_sclk | output | 2 | Serial clock per port |
| spi_cs_n | output | 2 | Active-low chip select per port |
| spi_sdo | output | 2 | Serial data out per port |
| spi_sdo_oe | output | 2 | Output enable of the data line per port |
| spi_sdi | input | 2 | Serial data in per port |

## Verification
The bound checker checks several rules on every cycle. At most one chip select is active at a time. The serial clock sits at the programmed idle level whenever no frame is running. A start is always followed by a running frame. The output enable is low during the receive phase of a 3-wire frame. The done flag goes up after each frame end and only falls on a clearing write. Other behaviours need the bench's scenarios, with a peripheral model on the pins:
- the bit order and length clamping
- the half-period length
- the received word in each wire mode
- that a held or disabled start launches nothing
- the chip-select hold across frames

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned OFS_CTRL = 'h180;
  localparam int unsigned OFS_TX   = 'h184;
  localparam int unsigned OFS_RX   = 'h188;
  localparam int unsigned OFS_STAT = 'h18C;

  typedef struct packed {
    logic [7:0] div;
    logic [7:0] rxf;
    logic [7:0] txf;
    logic       cpol;
    logic       keep;
    logic [1:0] rsvd;
    logic       en;
    logic       port;
    logic       three;
    logic       start;
  } ctrl_t;

  // Frame length from a minus-one field, clamped to 2..32.
  function automatic logic [5:0] frame_bits(input logic [7:0] f);
    if (f < 8'd1)       return 6'd2;
    else if (f > 8'd31) return 6'd32;
    else                return 6'(f + 8'd1);
  endfunction

  // Half-period length, never below 2 cycles.
  function automatic logic [7:0] half_cycles(input logic [7:0] d);
    return (d < 8'd2) ? 8'd2 : d;
  endfunction

endpackage

// File: rtl/spi_regs.sv
module spi_regs
  import panel_spi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  rx_word,
  input  logic              frame_end,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  tx_word,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              done,
  output logic              launch
);
  logic             start_q;
  logic [REG_W-1:0] rx_q;
  logic             wr_ctrl, wr_tx, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_tx   = reg_we && (reg_addr == ADDR_W'(OFS_TX));
  assign wr_stat = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
  assign launch  = ctrl.start && !start_q && ctrl.en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      tx_word <= '0;
      rx_q    <= '0;
      done    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= ctrl.start;
      if (wr_ctrl) begin
        ctrl      <= ctrl_t'(reg_wdata);
        ctrl.rsvd <= 2'b00;
      end
      if (wr_tx) tx_word <= reg_wdata;
      if (frame_end) begin
        rx_q <= rx_word;
        done <= 1'b1;
      end else if (wr_stat && !reg_wdata[0]) begin
        done <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(OFS_CTRL): reg_rdata = ctrl;
      ADDR_W'(OFS_TX):   reg_rdata = tx_word;
      ADDR_W'(OFS_RX):   reg_rdata = rx_q;
      ADDR_W'(OFS_STAT): reg_rdata = {{(REG_W-1){1'b0}}, done};
      default:           reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import panel_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [REG_W-1:0] tx_word,
  input  logic [5:0]       tx_bits,
  input  logic [5:0]       rx_bits,
  input  logic [7:0]       half,
  input  logic             three_wire,
  input  logic             keep,
  input  logic             enable,
  input  logic             sdi,
  output logic             busy,
  output logic             in_rx,
  output logic             sclk_act,
  output logic             cs_act,
  output logic             sdo_bit,
  output logic             sdo_en,
  output logic             frame_end,
  output logic [REG_W-1:0] rx_word
);
  logic             phase;
  logic [7:0]       hcnt, half_q;
  logic [5:0]       left;
  logic [REG_W-1:0] sh, rsh;
  logic             hold, three_q;
  logic             half_done;

  assign half_done = busy && (hcnt == 8'd0);
  assign frame_end = half_done && phase && (left == 6'd1) && (in_rx || !three_q);
  assign cs_act    = busy || hold;
  assign sclk_act  = busy && phase;
  assign sdo_bit   = busy && !in_rx && sh[REG_W-1];
  assign sdo_en    = cs_act && !(busy && in_rx);
  assign rx_word   = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; in_rx <= 1'b0; phase <= 1'b0; hcnt <= '0; half_q <= 8'd2;
      left <= '0; sh <= '0; rsh <= '0; hold <= 1'b0; three_q <= 1'b0;
    end else if (launch) begin
      busy    <= 1'b1;
      in_rx   <= 1'b0;
      phase   <= 1'b0;
      hcnt    <= half - 8'd1;
      half_q  <= half;
      three_q <= three_wire;
      left    <= tx_bits;
      sh      <= tx_word << (6'd32 - tx_bits);
      rsh     <= '0;
      hold    <= 1'b0;
    end else begin
      if (!keep || !enable) hold <= 1'b0;
      if (busy) begin
        if (hcnt != 8'd0) begin
          hcnt <= hcnt - 8'd1;
        end else begin
          hcnt <= half_q - 8'd1;
          if (!phase) begin
            phase <= 1'b1;
            rsh   <= {rsh[REG_W-2:0], sdi};
          end else begin
            phase <= 1'b0;
            sh    <= sh << 1;
            if (left == 6'd1) begin
              if (!in_rx && three_q) begin
                in_rx <= 1'b1;
                left  <= rx_bits;
                rsh   <= '0;
              end else begin
                busy  <= 1'b0;
                in_rx <= 1'b0;
                hold  <= keep && enable;
              end
            end else begin
              left <= left - 6'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_port_mux.sv
module spi_port_mux #(
  parameter int NPORTS = 2
) (
  input  logic              sel_port,
  input  logic              cpol,
  input  logic              sclk_act,
  input  logic              cs_act,
  input  logic              sdo_bit,
  input  logic              sdo_en,
  input  logic [NPORTS-1:0] spi_sdi,
  output logic [NPORTS-1:0] spi_sclk,
  output logic [NPORTS-1:0] spi_cs_n,
  output logic [NPORTS-1:0] spi_sdo,
  output logic [NPORTS-1:0] spi_sdo_oe,
  output logic              sdi_sel
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic mine;
    assign mine          = (32'(sel_port) == g);
    assign spi_sclk[g]   = mine ? (sclk_act ^ cpol) : cpol;
    assign spi_cs_n[g]   = !(mine && cs_act);
    assign spi_sdo[g]    = mine && sdo_bit;
    assign spi_sdo_oe[g] = mine && sdo_en;
  end
  assign sdi_sel = spi_sdi[sel_port];
endmodule

// File: rtl/panel_spi_master.sv
module panel_spi_master
  import panel_spi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              xfer_done,
  output logic [1:0]        spi_sclk,
  output logic [1:0]        spi_cs_n,
  output logic [1:0]        spi_sdo,
  output logic [1:0]        spi_sdo_oe,
  input  logic [1:0]        spi_sdi
);
  localparam int NPORTS = 2;

  ctrl_t            ctrl;
  logic [REG_W-1:0] tx_word, rx_word;
  logic             launch, busy, in_rx, frame_end;
  logic             sclk_act, cs_act, sdo_bit, sdo_en, sdi_sel;
  logic             cpol;

  assign cpol = ctrl.cpol;

  spi_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .rx_word(rx_word), .frame_end(frame_end),
    .busy(busy), .ctrl(ctrl), .tx_word(tx_word), .reg_rdata(reg_rdata),
    .done(xfer_done), .launch(launch)
  );

  spi_shift_engine u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .tx_word(tx_word),
    .tx_bits(frame_bits(ctrl.txf)), .rx_bits(frame_bits(ctrl.rxf)),
    .half(half_cycles(ctrl.div)), .three_wire(ctrl.three), .keep(ctrl.keep),
    .enable(ctrl.en), .sdi(sdi_sel), .busy(busy), .in_rx(in_rx),
    .sclk_act(sclk_act), .cs_act(cs_act), .sdo_bit(sdo_bit), .sdo_en(sdo_en),
    .frame_end(frame_end), .rx_word(rx_word)
  );

  spi_port_mux #(.NPORTS(NPORTS)) u_mux (
    .sel_port(ctrl.port), .cpol(cpol), .sclk_act(sclk_act), .cs_act(cs_act),
    .sdo_bit(sdo_bit), .sdo_en(sdo_en), .spi_sdi(spi_sdi), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .sdi_sel(sdi_sel)
  );
endmodule

// File: rtl/panel_spi_checker.sv
module panel_spi_checker
  import panel_spi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch,
  input logic              busy,
  input logic              in_rx,
  input logic              frame_end,
  input logic              cpol,
  input logic              xfer_done,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [1:0]        spi_cs_n,
  input logic [1:0]        spi_sclk,
  input logic [1:0]        spi_sdo_oe
);
  // R6
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == {2{cpol}}));

  // R2
  launch_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R8
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_rx) |-> (spi_sdo_oe == 2'b00));

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> xfer_done);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(reg_we && reg_addr == ADDR_W'(OFS_STAT) && !reg_wdata[0]))
      |=> xfer_done);
endmodule

bind panel_spi_master panel_spi_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .in_rx(in_rx),
  .frame_end(frame_end), .cpol(cpol), .xfer_done(xfer_done), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_sdo_oe(spi_sdo_oe)
);

// File: tb/test_panel_spi_master.sv
`timescale 1ns/1ps
module test_panel_spi_master;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_CTRL = 12'h180, A_TX = 12'h184, A_RX = 12'h188, A_ST = 12'h18C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, reg_we = 1'b0, xfer_done;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] spi_sclk, spi_cs_n, spi_sdo, spi_sdo_oe;
  logic [1:0] sdi_drv = 2'b00;

  panel_spi_master #(.ADDR_W(AW)) i_panel_spi_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .spi_sdi(sdi_drv)
  );

  int total = 0, bad = 0;
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {div, txf, rxf, cpol, port, three, tx, resp}
  localparam logic [90:0] VEC [8] = '{
    {8'd2, 8'd7,  8'd0,  1'b0, 1'b0, 1'b0, 32'h0000FFA5, 32'h0000003C},
    {8'd3, 8'd15, 8'd7,  1'b1, 1'b1, 1'b0, 32'h00001234, 32'h0000BEEF},
    {8'd2, 8'd8,  8'd11, 1'b0, 1'b0, 1'b1, 32'h00000155, 32'h00000ABC},
    {8'd4, 8'd31, 8'd0,  1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 32'h0F0F5AA5},
    {8'd2, 8'd1,  8'd1,  1'b1, 1'b0, 1'b1, 32'h00000002, 32'h00000001},
    {8'd5, 8'd23, 8'd31, 1'b0, 1'b1, 1'b1, 32'h00C0FFEE, 32'h80000001},
    {8'd0, 8'd0,  8'd0,  1'b0, 1'b0, 1'b1, 32'hFFFFFFFE, 32'h00000003},
    {8'd1, 8'd40, 8'd0,  1'b1, 1'b1, 1'b0, 32'h89ABCDEF, 32'h13579BDF}
  };

  function automatic int eff_len(input logic [7:0] f);
    if (f == 0) return 2;
    if (f >= 32) return 32;
    return int'(f) + 1;
  endfunction
  function automatic int eff_div(input logic [7:0] d);
    return (d <= 1) ? 2 : int'(d);
  endfunction
  function automatic logic [31:0] lowmask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  // Peripheral model
  logic [63:0] stream = '0;
  int pport = 0, k = 0, edges = 0, hi_run = 0, last_run = 0;
  logic pcpol = 1'b0, prev_act = 1'b0, prev_cs = 1'b0, other_moved = 1'b0;
  logic [31:0] cap = '0;

  always @(negedge clk) begin
    logic act, csl;
    int op;
    act = spi_sclk[pport] ^ pcpol;
    csl = !spi_cs_n[pport];
    op  = 1 - pport;
    if (csl && !prev_cs) begin
      k = 0;
      sdi_drv = 2'b00;
      sdi_drv[pport] = stream[63];
    end
    if (act && !prev_act) begin
      edges++;
      if (spi_sdo_oe[pport]) cap = {cap[30:0], spi_sdo[pport]};
    end
    if (!act && prev_act) begin
      k++;
      if (k < 64) sdi_drv[pport] = stream[63-k];
      last_run = hi_run;
    end
    hi_run = act ? hi_run + 1 : 0;
    if (spi_sclk[op] !== pcpol || spi_cs_n[op] !== 1'b1 || spi_sdo_oe[op] !== 1'b0)
      other_moved = 1'b1;
    prev_act = act;
    prev_cs  = csl;
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask
  task automatic wait_done(output logic [31:0] v);
    int w = 0;
    do begin rd(A_ST, v); w++; end while (!v[0] && w < 40000);
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [90:0] e, input logic keep, input logic start);
    return {e[90:83], e[74:67], e[82:75], e[66], keep, 2'b00, 1'b1, e[65], e[64], start};
  endfunction

  task automatic run(input int idx, input logic keep);
    logic [90:0] e;
    logic [31:0] cfg, v;
    int ntx, nrx, d, nsamp;
    e = VEC[idx];
    ntx = eff_len(e[82:75]); nrx = eff_len(e[74:67]); d = eff_div(e[90:83]);
    cfg = mk_ctrl(e, keep, 1'b0);
    wr(A_CTRL, cfg);
    wr(A_TX, e[63:32]);
    repeat (4) @(negedge clk);
    pport = int'(e[65]); pcpol = e[66];
    nsamp = e[64] ? nrx : ntx;
    if (e[64]) stream = ({e[31:0], 32'h0} << (32 - nrx)) >> ntx;
    else       stream = {e[31:0], 32'h0} << (32 - ntx);
    repeat (2) @(negedge clk);
    edges = 0; cap = '0; other_moved = 1'b0; last_run = 0;
    wr(A_CTRL, cfg | 32'h1);
    wait_done(v);
    check($sformatf("R9 done vec%0d", idx), {31'd0, v[0]}, 32'd1);
    check($sformatf("R3 tx bits vec%0d", idx), cap, e[63:32] & lowmask(ntx));
    check($sformatf("R3/R8 clock count vec%0d", idx), edges, e[64] ? ntx + nrx : ntx);
    check($sformatf("R4 half period vec%0d", idx), last_run, d);
    check($sformatf("R6 other port idle vec%0d", idx), {31'd0, other_moved}, 32'd0);
    check($sformatf("R5 idle level vec%0d", idx), {31'd0, spi_sclk[pport]}, {31'd0, e[66]});
    rd(A_RX, v);
    check($sformatf("%s rx word vec%0d", e[64] ? "R8" : "R7", idx), v, e[31:0] & lowmask(nsamp));
    check($sformatf("R10 cs after frame vec%0d", idx), {31'd0, spi_cs_n[pport]}, {31'd0, !keep});
    wr(A_CTRL, cfg);
    wr(A_ST, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 cs_n", {30'd0, spi_cs_n}, 32'h3);
    check("R11 sclk", {30'd0, spi_sclk}, 32'h0);
    check("R11 oe", {30'd0, spi_sdo_oe}, 32'h0);
    check("R11 done", {31'd0, xfer_done}, 32'h0);
    rst_n = 1'b1;
    rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
    rd(A_ST, v);   check("R1 status reset", v, 32'h0);
    // R1 readback with reserved bits
    wr(A_CTRL, 32'h12345676);
    rd(A_CTRL, v); check("R1 ctrl readback", v, 32'h12345646);
    wr(A_TX, 32'hCAFEF00D);
    rd(A_TX, v);   check("R1 tx readback", v, 32'hCAFEF00D);
    wr(A_CTRL, 32'h0);
    // R2 start while disabled
    wr(A_CTRL, 32'h02000701);
    repeat (100) @(negedge clk);
    check("R2 disabled no cs", {30'd0, spi_cs_n}, 32'h3);
    rd(A_ST, v); check("R2 disabled no done", v, 32'h0);
    wr(A_CTRL, 32'h0);

    for (int i = 0; i < 8; i++) run(i, 1'b0);

    // R10 keep chip select
    run(0, 1'b1);
    check("R10 cs held with start low", {31'd0, spi_cs_n[0]}, 32'd0);
    wr(A_CTRL, mk_ctrl(VEC[0], 1'b0, 1'b0));
    @(negedge clk);
    check("R10 cs released", {31'd0, spi_cs_n[0]}, 32'd1);

    // R2 held start, R9 sticky clear
    wr(A_TX, 32'h5A);
    wr(A_CTRL, mk_ctrl(VEC[0], 1'b0, 1'b1));
    wait_done(v);
    repeat (20) @(negedge clk);
    rd(A_ST, v); check("R9 stays set", v, 32'h1);
    wr(A_ST, 32'h1);
    rd(A_ST, v); check("R9 write one keeps", v, 32'h1);
    wr(A_ST, 32'h0);
    rd(A_ST, v); check("R9 write zero clears", v, 32'h0);
    repeat (200) @(negedge clk);
    rd(A_ST, v); check("R2 held start no relaunch", v, 32'h0);
    check("R2 held start cs idle", {30'd0, spi_cs_n}, 32'h3);
    wr(A_CTRL, mk_ctrl(VEC[0], 1'b0, 1'b0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule